// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a synthesizable behavioural model of a byte-wide serial EEPROM that answers on a two-wire open-drain bus. It samples the bus clock and data lines with the system clock, detects START and STOP conditions, and answers when the device select byte carries the fixed tag and matches the two chip-select strap inputs. It never drives the data line high. It only enables a pull-down, and the board or bench supplies the pull-up.

A write transfer carries a two-byte word address, most significant byte first, and then any number of data bytes. The data bytes collect in a one-page buffer whose offset wraps inside the page. They are committed to the internal array only when the STOP arrives. The array is then busy for a fixed number of system clocks, and the device select is refused until that time has passed. A read transfer streams bytes from a persistent address pointer. The master uses a repeated START after an address-only write to read from any location. A write-protect input keeps the array and the busy timer untouched, but the block still acknowledges every byte.

The bus pins are plain pins, with no valid/ready handshake, because the bus sets the pace. The bus master must keep SCL high and low for at least about five system clocks each, so that the synchronizers resolve every edge.

Top module: `ee2w_target`

## Requirements
- R1: A START (SDA falling while SCL is high) starts a new transfer from any state. A STOP (SDA rising while SCL is high) returns the block to idle, and it then ignores clocked bits until the next START.
- R2: The device select byte is `1010 0` in bits 7:3, then the two strap bits in bits 2:1, then R/W in bit 0 (1 = read). On a match the block pulls SDA low for the 9th clock.
- R3: A select byte whose strap bits or tag do not match gets no acknowledge, and the rest of that transfer is ignored.
- R4: After a write select, the block receives two address bytes, high byte first, and acknowledges each. Only the low log2(MEM_DEPTH) bits of the 16 bits are kept.
- R5: Each data byte of a write is acknowledged and placed at the pointer. Only the low 6 pointer bits then advance, wrapping inside the 64-byte page, so bytes beyond 64 overwrite the earliest ones.
- R6: Buffered write data reaches the array only at STOP. The busy window then lasts BUSY_CYCLES system clocks, and during it the device select is not acknowledged and SDA is never pulled.
- R7: While wp_i is high at STOP, the array keeps its contents and no busy window starts. Every byte of the transfer is still acknowledged.
- R8: A read select with no preceding address returns the byte at the pointer, which holds the last accessed address plus one.
- R9: An address-only write followed by a repeated START and a read select returns data from that address.
- R10: In a read, a master ACK after a byte advances the pointer and sends the next byte. A master NACK ends the read and leaves SDA released.
- R11: During reads the pointer wraps from MEM_DEPTH-1 to 0.
- R12: The target pull-down only changes while SCL is low, except that it is released at START and STOP.
- R13: After reset SDA is released and the block is idle and not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | 1 enables the pull-down on the data line |
| strap_i | input | 2 | Chip-select straps compared with select bits 2:1 |
| wp_i | input | 1 | 1 suppresses all array writes |

## Verification
The bench writes four bytes starting two bytes before a page end and reads them back. A design that carried into the page bits would place the last two bytes in the next page. A 66-byte write checks that the first two locations are overwritten while the third survives, and a read across the top address checks that the pointer wraps to zero rather than stalling. A select sent right after a write STOP must be refused until the busy window ends, and a write-protected transfer must be acknowledged yet leave both the data and the busy state untouched. A wrong strap or a byte clocked after STOP must draw no acknowledge, which catches a design that decodes too loosely or never truly returns to idle.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;
  localparam logic [4:0] DEV_TAG = 5'b10100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } ee_state_t;
endpackage

// File: rtl/ee2w_edge.sv
module ee2w_edge #(
  parameter int SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic sda_lv,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  localparam int SW = SYNC_LEN + 1;

  logic [SW-1:0] scl_sh, sda_sh;
  logic scl_old, sda_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[SW-2:0], scl_i};
      sda_sh <= {sda_sh[SW-2:0], sda_i};
    end
  end

  assign scl_hi   = scl_sh[SW-2];
  assign sda_lv   = sda_sh[SW-2];
  assign scl_old  = scl_sh[SW-1];
  assign sda_old  = sda_sh[SW-1];
  assign scl_rise = scl_hi & ~scl_old;
  assign scl_fall = ~scl_hi & scl_old;
  assign ev_start = scl_hi & scl_old & sda_old & ~sda_lv;
  assign ev_stop  = scl_hi & scl_old & ~sda_old & sda_lv;
endmodule

// File: rtl/ee2w_store.sv
module ee2w_store #(
  parameter int MEM_DEPTH   = 512,
  parameter int PAGE_BYTES  = 64,
  parameter int BUSY_CYCLES = 600
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      buf_we,
  input  logic [$clog2(PAGE_BYTES)-1:0]             buf_off,
  input  logic [7:0]                                buf_data,
  input  logic                                      buf_clr,
  input  logic                                      commit,
  input  logic [$clog2(MEM_DEPTH/PAGE_BYTES)-1:0]   commit_page,
  input  logic [$clog2(MEM_DEPTH)-1:0]              rd_addr,
  output logic [7:0]                                rd_data,
  output logic                                      busy_o
);
  localparam int PW  = $clog2(PAGE_BYTES);
  localparam int NPW = $clog2(MEM_DEPTH / PAGE_BYTES);
  localparam int CW  = $clog2(BUSY_CYCLES + 1);

  logic [7:0]            mem  [MEM_DEPTH];
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pval;
  logic [CW-1:0]         cnt;
  logic                  busy;
  logic [NPW-1:0]        page_q;
  logic                  drain;
  logic [PW-1:0]         doff;

  assign drain   = busy && (cnt < CW'(PAGE_BYTES));
  assign doff    = cnt[PW-1:0];
  assign busy_o  = busy;
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      page_q <= '0;
      pval   <= '0;
    end else begin
      if (commit) begin
        busy   <= 1'b1;
        cnt    <= '0;
        page_q <= commit_page;
      end else if (busy) begin
        if (cnt == CW'(BUSY_CYCLES - 1)) begin
          busy <= 1'b0;
          pval <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (buf_clr)     pval          <= '0;
      else if (buf_we) pval[buf_off] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_off] <= buf_data;
    if (drain && pval[doff]) mem[{page_q, doff}] <= pbuf[doff];
  end

  AST_NO_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !busy); // R6
  AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit)); // R6
endmodule

// File: rtl/ee2w_target.sv
module ee2w_target
  import ee2w_pkg::*;
#(
  parameter int MEM_DEPTH   = 512,
  parameter int PAGE_BYTES  = 64,
  parameter int BUSY_CYCLES = 600,
  parameter int SYNC_LEN    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [1:0] strap_i,
  input  logic       wp_i
);
  localparam int AW = $clog2(MEM_DEPTH);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int HW = AW - 8;

  logic scl_hi, sda_lv, scl_rise, scl_fall, ev_start, ev_stop;

  ee2w_edge #(.SYNC_LEN(SYNC_LEN)) u_edge (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_hi(scl_hi), .sda_lv(sda_lv), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  ee_state_t     st;
  logic [3:0]    bitc;
  logic [7:0]    shreg, outreg, rd_data;
  logic [HW-1:0] addr_hi;
  logic [AW-1:0] ptr;
  logic          ack_drv, rd_drv, mack, wr_pend, busy;
  logic          byte_end, dev_hit, buf_we, buf_clr, commit;

  assign byte_end = scl_fall && (bitc == 4'd8);
  assign dev_hit  = (shreg[7:3] == DEV_TAG) && (shreg[2:1] == strap_i) && !busy;
  assign buf_we   = byte_end && (st == ST_WDAT);
  assign buf_clr  = byte_end && (st == ST_DEV) && dev_hit && !shreg[0];
  assign commit   = ev_stop && wr_pend && !wp_i;
  assign sda_pull_o = ack_drv | rd_drv;

  ee2w_store #(.MEM_DEPTH(MEM_DEPTH), .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_off(ptr[PW-1:0]), .buf_data(shreg),
    .buf_clr(buf_clr), .commit(commit), .commit_page(ptr[AW-1:PW]),
    .rd_addr(ptr), .rd_data(rd_data), .busy_o(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bitc <= '0; shreg <= '0; outreg <= '0; addr_hi <= '0;
      ptr <= '0; ack_drv <= 1'b0; rd_drv <= 1'b0; mack <= 1'b0; wr_pend <= 1'b0;
    end else if (ev_start || ev_stop) begin
      st      <= ev_start ? ST_DEV : ST_IDLE;
      bitc    <= '0;
      ack_drv <= 1'b0;
      rd_drv  <= 1'b0;
      wr_pend <= 1'b0;
    end else if (st != ST_IDLE) begin
      if (scl_rise) begin
        if (bitc < 4'd8) shreg <= {shreg[6:0], sda_lv};
        else if (bitc == 4'd8) mack <= !sda_lv;
        if (bitc != 4'd9) bitc <= bitc + 1'b1;
      end else if (byte_end) begin
        case (st)
          ST_DEV: begin
            if (dev_hit) begin
              ack_drv <= 1'b1;
              mack    <= 1'b1;
              st      <= shreg[0] ? ST_RDAT : ST_AHI;
            end else begin
              st <= ST_IDLE;
            end
          end
          ST_AHI: begin
            ack_drv <= 1'b1;
            addr_hi <= shreg[HW-1:0];
            st      <= ST_ALO;
          end
          ST_ALO: begin
            ack_drv <= 1'b1;
            ptr     <= {addr_hi, shreg};
            st      <= ST_WDAT;
          end
          ST_WDAT: begin
            ack_drv <= 1'b1;
            wr_pend <= 1'b1;
            ptr     <= {ptr[AW-1:PW], PW'(ptr[PW-1:0] + 1'b1)};
          end
          ST_RDAT: begin
            rd_drv <= 1'b0;
            ptr    <= ptr + 1'b1;
          end
          default: st <= ST_IDLE;
        endcase
      end else if (scl_fall && bitc == 4'd9) begin
        ack_drv <= 1'b0;
        bitc    <= '0;
        if (st == ST_RDAT) begin
          if (mack) begin
            outreg <= rd_data;
            rd_drv <= !rd_data[7];
          end else begin
            st <= ST_IDLE;
          end
        end
      end else if (scl_fall && st == ST_RDAT && bitc != 4'd0) begin
        outreg <= {outreg[6:0], 1'b0};
        rd_drv <= !outreg[6];
      end
    end
  end

  AST_QUIET_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull_o); // R6
  AST_NO_PULL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hi && $past(scl_hi)) |-> !$rose(sda_pull_o)); // R12
  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WDAT && $past(st) == ST_WDAT) |-> ptr[AW-1:PW] == $past(ptr[AW-1:PW])); // R5
  AST_WP_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp_i)); // R7
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ev_stop) && st == ST_IDLE) |-> !sda_pull_o); // R1
endmodule

// File: tb/ee2w_target_test.sv
module ee2w_target_test;
  localparam int Q = 5;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic wp = 1'b0;
  logic sda_pull;
  logic sda_bus;
  int   n_chk = 0;
  int   n_fail = 0;
  logic [7:0] rbuf [0:7];

  localparam logic [7:0] DEV_W = 8'hA2;
  localparam logic [7:0] DEV_R = 8'hA3;

  always #10 clk = ~clk;
  assign sda_bus = !(m_low || sda_pull);

  ee2w_target #(.MEM_DEPTH(512), .PAGE_BYTES(64), .BUSY_CYCLES(600), .SYNC_LEN(2)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_pull_o(sda_pull),
    .strap_i(2'b01), .wp_i(wp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wait_clk(Q); scl = 1'b1; wait_clk(H);
    m_low = 1'b1; wait_clk(H); scl = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wait_clk(Q); scl = 1'b1; wait_clk(H);
    m_low = 1'b0; wait_clk(H);
  endtask

  task automatic wbit(input logic b);
    m_low = !b; wait_clk(Q); scl = 1'b1; wait_clk(H); scl = 1'b0; wait_clk(Q);
  endtask

  task automatic rbit(output logic b);
    m_low = 1'b0; wait_clk(Q); scl = 1'b1; wait_clk(H - 1);
    b = sda_bus; wait_clk(1); scl = 1'b0; wait_clk(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    ack = !b;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      v[i] = b;
    end
    wbit(!give_ack);
  endtask

  task automatic probe(output logic ack);
    bus_start(); send_byte(DEV_W, ack); bus_stop();
  endtask

  task automatic poll_ready();
    logic ack = 1'b0;
    for (int i = 0; i < 40 && !ack; i++) probe(ack);
    chk("R6 device ready after busy window", ack, 1);
  endtask

  task automatic do_write(input logic [15:0] addr, input int n, input logic [7:0] first);
    logic ack;
    bus_start();
    send_byte(DEV_W, ack);     chk("R2 write select ack", ack, 1);
    send_byte(addr[15:8], ack); chk("R4 address high ack", ack, 1);
    send_byte(addr[7:0], ack);  chk("R4 address low ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(first + 8'(i), ack);
      if (!ack) chk("R5 data byte ack", ack, 1);
    end
    bus_stop();
  endtask

  task automatic rand_read(input logic [15:0] addr, input int n);
    logic ack;
    bus_start();
    send_byte(DEV_W, ack);      chk("R9 address write select ack", ack, 1);
    send_byte(addr[15:8], ack); chk("R9 address high ack", ack, 1);
    send_byte(addr[7:0], ack);  chk("R9 address low ack", ack, 1);
    bus_start();
    send_byte(DEV_R, ack);      chk("R9 read select ack", ack, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic cur_read(input int n);
    logic ack;
    bus_start();
    send_byte(DEV_R, ack); chk("R8 current read select ack", ack, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic t_reset();
    wait_clk(3);
    chk("R13 SDA released after reset", sda_bus, 1);
    chk("R13 no pull after reset", sda_pull, 0);
  endtask

  task automatic t_byte_write();
    logic ack;
    do_write(16'h0010, 1, 8'h11);
    probe(ack);
    chk("R6 select refused while busy", ack, 0);
    poll_ready();
    rand_read(16'h0010, 1);
    chk("R9 random read of written byte", rbuf[0], 8'h11);
  endtask

  task automatic t_page_wrap();
    do_write(16'h007E, 4, 8'hA0);
    poll_ready();
    rand_read(16'h007E, 2);
    chk("R10 sequential byte 0", rbuf[0], 8'hA0);
    chk("R10 sequential byte 1", rbuf[1], 8'hA1);
    rand_read(16'h0040, 1);
    chk("R5 wrapped byte at page start", rbuf[0], 8'hA2);
    cur_read(1);
    chk("R8 current address after read", rbuf[0], 8'hA3);
  endtask

  task automatic t_overwrite();
    do_write(16'h0080, 66, 8'h01);
    poll_ready();
    rand_read(16'h0080, 3);
    chk("R5 first byte overwritten", rbuf[0], 8'h41);
    chk("R5 second byte overwritten", rbuf[1], 8'h42);
    chk("R5 third byte kept", rbuf[2], 8'h03);
  endtask

  task automatic t_wrap_top();
    do_write(16'h7FFF, 1, 8'h5A);
    poll_ready();
    do_write(16'h0000, 1, 8'hC3);
    poll_ready();
    rand_read(16'h01FF, 2);
    chk("R4 upper address bits dropped", rbuf[0], 8'h5A);
    chk("R11 pointer wraps to zero", rbuf[1], 8'hC3);
    chk("R10 SDA released after NACK", sda_bus, 1);
  endtask

  task automatic t_wp();
    logic ack;
    wp = 1'b1;
    do_write(16'h0010, 1, 8'hEE);
    probe(ack);
    chk("R7 no busy window under write protect", ack, 1);
    wp = 1'b0;
    rand_read(16'h0010, 1);
    chk("R7 array unchanged under write protect", rbuf[0], 8'h11);
  endtask

  task automatic t_strap();
    logic ack;
    bus_start();
    send_byte(8'hA0, ack); chk("R3 strap mismatch not acked", ack, 0);
    send_byte(8'hFF, ack); chk("R3 later byte ignored", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'hB2, ack); chk("R3 tag mismatch not acked", ack, 0);
    bus_stop();
    bus_start();
    send_byte(DEV_R, ack); chk("R2 read select ack", ack, 1);
    recv_byte(1'b0, rbuf[0]);
    bus_stop();
  endtask

  task automatic t_after_stop();
    logic ack;
    send_byte(DEV_W, ack);
    chk("R1 bits after STOP ignored", ack, 0);
    bus_start();
    send_byte(DEV_W, ack);
    chk("R1 START restarts transfer", ack, 1);
    bus_stop();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    t_reset();
    t_byte_write();
    t_page_wrap();
    t_overwrite();
    t_wrap_top();
    t_wp();
    t_strap();
    t_after_stop();
    wait_clk(10);
    finish_run();
  end
endmodule